// File: doc/BRIEF.md
# Configurable Bus Cycle Sequencer

This block turns single CPU transfer requests into timed bus cycles for three on-chip memory zones. A request carries a direction, an address and write data. The sequencer decodes the target zone from the top two address bits and drives a zone select, a latched address, read and write strobes and the write data. When the transfer ends, it gives a one-clock done pulse with the read data.

Each transfer has a base shape set by its type. A normal read takes two clocks and a fast read takes one. A late write takes two clocks and an early write takes three. Wait clocks go in directly after the address phase. Hold clocks go on the end of the transfer, after the strobe has dropped, and the address and write data stay driven through them. A mode register picks early or late writes. Each zone has its own register that sets the wait count, the hold count and whether reads are fast.

The configuration registers are written and read through a small select/data port. The CPU side has a ready signal that is high only while the sequencer is idle.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, the mode register reads 07h, every zone register reads 1Fh (wait 7, hold 3, fast read off), req_ready is 1 and done is 0.
- R2: Mode register (cfg_sel 0). Bit 0 selects early writes when 1 and late writes when 0. Bits 2:1 are stored and read back. Bits 7:3 read as 0.
- R3: Zone registers: cfg_sel 1 is the I/O zone, 2 is static zone 0 and 3 is static zone 1. In each, bits 2:0 are the wait count, bits 4:3 are the hold count and bit 5 enables fast reads. Bits 7:6 read as 0.
- R4: The top two address bits pick the zone: 00 is static zone 0 (zone_sel bit 1), 01 is static zone 1 (bit 2), 10 is the I/O zone (bit 0) and 11 is unmapped (zone_sel 0). zone_sel stays at its one-hot value for every clock of the transfer and is 0 when idle.
- R5: Counting the first clock after the accepting edge as clock 1, done is high in clock N. N is the base length plus W plus H. The base length is 2 for a normal read, 1 for a fast read, 2 for a late write and 3 for an early write.
- R6: Wait clocks come after the address clock. A normal read strobes bus_rd in clocks 1 to W+2. A fast read strobes it in clocks 1 to W+1. A write strobes bus_wr in exactly one clock, clock W+2.
- R7: bus_addr and bus_wdata keep the request's values for the whole transfer. Both strobes are low in the hold clocks.
- R8: done is high for exactly one clock. In that clock, rdata equals the memory data present in the last read-strobe clock. rdata is 0 when done is low.
- R9: A request is taken only when req_ready is 1. A request raised while a transfer is running is ignored and does not change bus_addr.
- R10: An unmapped access asserts no zone select and no strobe. It uses W=0, H=0 and normal-read timing, with writes still following the mode register, and it returns rdata 0.
- R11: Timing is latched when the request is taken. A register write during a transfer does not change that transfer's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | CPU transfer request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Read data, valid while done is high |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 I/O zone, 2 static zone 0, 3 static zone 1 |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read-back of the selected register |
| zone_sel | output | 3 | One-hot zone select: bit 0 I/O, bit 1 static 0, bit 2 static 1 |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Data returned by the selected memory |

## Verification
The assertions check on every clock that done never lasts two clocks and that zone_sel is one-hot or zero. They also check that the write strobe is a single-clock pulse, that no strobe appears while idle or on an unmapped access, and that the address and write data stay stable within a transfer. The exact transfer length for each cycle type and each wait and hold count, the clock in which each strobe appears, the read data returned and the effect of register programming can only be shown by the bench. It sweeps every combination of direction, type, wait count and hold count, and checks each one against expected values it computes itself.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  output logic [2:0]    zone_sel,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  localparam logic [5:0] ZONE_RST = 6'b011111;

  logic [2:0]    mode_q;
  logic [5:0]    zio_q, zs0_q, zs1_q;
  logic          busy_q, wr_q, mapped_q;
  logic [3:0]    pos_q, dp_q, last_q;
  logic [2:0]    zsel_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rd_q;

  logic          accept, mapped_n;
  logic [2:0]    zsel_n;
  logic [5:0]    tcfg;
  logic [3:0]    dp_n, last_n;

  always_comb begin
    mapped_n = 1'b1;
    zsel_n   = 3'b000;
    tcfg     = 6'b0;
    case (req_addr[AW-1:AW-2])
      2'b00:   begin zsel_n = 3'b010; tcfg = zs0_q; end
      2'b01:   begin zsel_n = 3'b100; tcfg = zs1_q; end
      2'b10:   begin zsel_n = 3'b001; tcfg = zio_q; end
      default: mapped_n = 1'b0;
    endcase
  end

  assign dp_n   = 4'(tcfg[2:0]) + ((req_write || !tcfg[5]) ? 4'd1 : 4'd0);
  assign last_n = dp_n + ((req_write && mode_q[0]) ? 4'd1 : 4'd0) + 4'(tcfg[4:3]);
  assign accept = req_valid && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'b111;
      zio_q  <= ZONE_RST;
      zs0_q  <= ZONE_RST;
      zs1_q  <= ZONE_RST;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    mode_q <= cfg_wdata[2:0];
        2'd1:    zio_q  <= cfg_wdata[5:0];
        2'd2:    zs0_q  <= cfg_wdata[5:0];
        default: zs1_q  <= cfg_wdata[5:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      wr_q     <= 1'b0;
      mapped_q <= 1'b0;
      pos_q    <= '0;
      dp_q     <= '0;
      last_q   <= '0;
      zsel_q   <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_q     <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      wr_q     <= req_write;
      mapped_q <= mapped_n;
      pos_q    <= '0;
      dp_q     <= dp_n;
      last_q   <= last_n;
      zsel_q   <= zsel_n;
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
    end else if (busy_q) begin
      if (pos_q == last_q) busy_q <= 1'b0;
      else                 pos_q  <= pos_q + 4'd1;
      if (!wr_q && pos_q == dp_q) rd_q <= mapped_q ? bus_rdata : '0;
    end
  end

  assign req_ready = !busy_q;
  assign done      = busy_q && (pos_q == last_q);
  assign bus_rd    = busy_q && mapped_q && !wr_q && (pos_q <= dp_q);
  assign bus_wr    = busy_q && mapped_q && wr_q && (pos_q == dp_q);
  assign zone_sel  = busy_q ? zsel_q : 3'b000;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign rdata     = !(done && !wr_q) ? '0 :
                     (pos_q == dp_q)  ? (mapped_q ? bus_rdata : '0) : rd_q;

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = {5'b0, mode_q};
      2'd1:    cfg_rdata = {2'b0, zio_q};
      2'd2:    cfg_rdata = {2'b0, zs0_q};
      default: cfg_rdata = {2'b0, zs1_q};
    endcase
  end
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [2:0]    zone_sel,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(zone_sel) && (req_ready -> zone_sel == 3'b000));
  a_r6_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);
  a_r9_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr || done) |-> !req_ready);
  a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && zone_sel == 3'b000) |-> (!bus_rd && !bus_wr));
  a_r7_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> ($stable(bus_addr) && $stable(bus_wdata)));
endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .zone_sel(zone_sel),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [15:0] MEM_KEY = 16'h5A3C;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, done;
  logic [DW-1:0] rdata;
  logic          cfg_we = 0;
  logic [1:0]    cfg_sel = 0;
  logic [7:0]    cfg_wdata = 0, cfg_rdata;
  logic [2:0]    zone_sel;
  logic [AW-1:0] bus_addr;
  logic          bus_rd, bus_wr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;

  assign bus_rdata = bus_rd ? (bus_addr ^ MEM_KEY) : 16'hDEAD;

  always #5 clk = ~clk;

  bus_cycle_seq #(.AW(AW), .DW(DW)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_check(input logic [1:0] sel, input logic [7:0] exp, input string req);
    @(negedge clk);
    cfg_sel = sel;
    #1;
    chk(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  task automatic xfer(input bit wr, input logic [15:0] addr, input logic [15:0] wd,
                      input int w, input int h, input bit fast, input bit early,
                      input bit poke);
    int dp, n_exp, n, rd_cnt, wr_cnt, wr_first;
    bit seen, sel_bad, wd_bad;
    logic [2:0] exp_sel;
    logic [15:0] got, exp_rd;
    bit mapped;
    mapped = (addr[15:14] != 2'b11);
    case (addr[15:14])
      2'b00: exp_sel = 3'b010;
      2'b01: exp_sel = 3'b100;
      2'b10: exp_sel = 3'b001;
      default: exp_sel = 3'b000;
    endcase
    if (!mapped) begin w = 0; h = 0; fast = 0; end
    dp = ((wr || !fast) ? 1 : 0) + w;
    n_exp = dp + 1 + ((wr && early) ? 1 : 0) + h;
    exp_rd = mapped ? (addr ^ MEM_KEY) : 16'h0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready when idle", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    n = 0; rd_cnt = 0; wr_cnt = 0; wr_first = 0; seen = 0; sel_bad = 0; wd_bad = 0; got = 0;
    while (!seen && n < 40) begin
      @(negedge clk);
      n++;
      if (n == 1) req_valid = 0;
      if (poke && n == 2) begin
        req_valid = 1; req_addr = addr ^ 16'h0F0F;
        cfg_we = 1; cfg_sel = 2'd2; cfg_wdata = 8'h00;
      end
      if (poke && n == 3) begin req_valid = 0; cfg_we = 0; end
      if (bus_rd) rd_cnt++;
      if (bus_wr) begin wr_cnt++; if (wr_first == 0) wr_first = n; end
      if (zone_sel != exp_sel) sel_bad = 1;
      if (bus_addr != addr || (wr && bus_wdata != wd)) wd_bad = 1;
      if (done) begin seen = 1; got = rdata; end
    end
    req_valid = 0; cfg_we = 0;
    chk(n == n_exp, poke ? "R11 length unchanged by cfg write" : "R5 cycle length", n, n_exp);
    chk(!sel_bad, "R4 zone select", zone_sel, exp_sel);
    chk(!wd_bad, "R7 address/data held", bus_addr, addr);
    if (wr) begin
      chk(wr_cnt == (mapped ? 1 : 0), mapped ? "R6 write strobe count" : "R10 no strobe",
          wr_cnt, mapped ? 1 : 0);
      if (mapped) chk(wr_first == dp + 1, "R6 write strobe position", wr_first, dp + 1);
    end else begin
      chk(rd_cnt == (mapped ? dp + 1 : 0), mapped ? "R6 read strobe span" : "R10 no strobe",
          rd_cnt, mapped ? dp + 1 : 0);
      chk(got == exp_rd, mapped ? "R8 read data" : "R10 unmapped data zero", got, exp_rd);
    end
    @(negedge clk);
    chk(done == 1'b0 && rdata == '0, "R8 done single pulse", done, 0);
    chk(req_ready == 1'b1 && bus_addr == addr, "R9 idle after done, busy request ignored",
        bus_addr, addr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R1 idle after reset", {req_ready, done}, 2'b10);
    cfg_check(2'd0, 8'h07, "R1 mode reset");
    for (int s = 1; s < 4; s++) cfg_check(2'(s), 8'h1F, "R1 zone reset");

    // R1: default timing is normal read, early write, wait 7, hold 3
    xfer(0, 16'h0123, 16'h0, 7, 3, 0, 1, 0);
    xfer(1, 16'h0456, 16'hBEEF, 7, 3, 0, 1, 0);

    cfg_write(2'd0, 8'hFE);
    cfg_check(2'd0, 8'h06, "R2 mode reserved bits read zero");
    cfg_write(2'd1, 8'hFF);
    cfg_check(2'd1, 8'h3F, "R3 zone upper bits read zero");
    cfg_write(2'd3, 8'h2A);
    cfg_check(2'd3, 8'h2A, "R3 zone field store");

    for (int wr = 0; wr < 2; wr++)
      for (int v = 0; v < 2; v++)
        for (int w = 0; w < 8; w++)
          for (int h = 0; h < 4; h++) begin
            cfg_write(2'd0, wr ? (v ? 8'h07 : 8'h06) : 8'h06);
            cfg_write(2'd2, 8'((!wr && v) << 5 | h << 3 | w));
            xfer(wr[0], 16'h0000 | 16'(w * 64 + h * 4 + v), 16'(16'hA000 + w * 16 + h),
                 w, h, !wr && v, wr && v, 0);
          end

    cfg_write(2'd0, 8'h06);
    cfg_write(2'd1, 8'h22);
    xfer(0, 16'h8A10, 16'h0, 2, 0, 1, 0, 0);
    xfer(1, 16'h8A12, 16'h1234, 2, 0, 1, 0, 0);
    cfg_write(2'd3, 8'h0B);
    xfer(0, 16'h4321, 16'h0, 3, 1, 0, 0, 0);
    xfer(1, 16'h4322, 16'h4444, 3, 1, 0, 0, 0);

    // R10 unmapped
    xfer(0, 16'hC100, 16'h0, 0, 0, 0, 0, 0);
    xfer(1, 16'hC200, 16'h7777, 0, 0, 0, 0, 0);
    cfg_write(2'd0, 8'h07);
    xfer(1, 16'hC300, 16'h8888, 0, 0, 0, 1, 0);

    // R11 and R9: register write and request while busy
    cfg_write(2'd2, 8'h1F);
    xfer(0, 16'h1111, 16'h0, 7, 3, 0, 0, 1);
    cfg_write(2'd2, 8'h1F);
    xfer(1, 16'h2222, 16'h9999, 7, 3, 0, 1, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule